// File: doc/BRIEF.md
# DDR Write Leveling Calibration Controller

This controller aligns the write strobe of each data byte group of a DDR memory interface with the memory clock. After a start request it works through the byte groups one after the other, beginning with group 0. For each group it walks an external output delay line upward one step at a time. Fine steps come first. A coarse step is taken whenever the fine setting is already at its top. After every step the controller waits for the line to settle. It then takes a short burst of samples of the feedback bit that the memory returns on the data lines, and looks for the point where that feedback changes from a clean 0 to a clean 1.

The tap position where the first clean 1 appears is stored for each group. Logic outside the block can read it back at any time by group index. If a group never shows the transition before the delay line runs out, the pass stops at that group and reports an error. Otherwise it reports done once every group has passed. The current state, the group being worked on, a sampling-window flag and an edge-found flag are brought out for debug.

The delay line is driven through a request/acknowledge step handshake. The feedback bit is an ordinary input that is sampled synchronously.

Top module: `wl_cal_ctrl`

## Requirements
- R1: A synchronous active-high reset returns the controller to idle, with `wl_state` reading 0. It clears `wl_started`, `wl_done`, `wl_err`, `edge_found`, `win_valid` and `tap_inc_req`, sets `cur_grp` to 0 and zeroes every stored tap record.
- R2: A one-cycle `cal_req` while idle, done or failed starts a new pass. The start clears done, error and all tap records, and raises `wl_started`, which stays high until reset. A `cal_req` that arrives while a pass is running has no effect on the pass or on its results.
- R3: Groups are calibrated in ascending order starting at 0. `cur_grp` names the group in progress and only ever steps up by one during a pass. `wl_state` reads 5 for the one cycle in which the pass moves to the next group.
- R4: Within a group the tap position starts at fine 0, coarse 0. Each step either raises fine by one (`tap_coarse`=0) or, when fine is 63, requests a coarse step (`tap_coarse`=1). A coarse step raises coarse by one and returns fine to 0. Coarse never goes beyond 7.
- R5: After every delay step, and at the start of every group, the controller waits 8 cycles. It then raises `win_valid` for exactly 4 consecutive cycles, during which it samples `dq_fb`. `win_valid` is low at all other times and is never high while a step is requested.
- R6: A tap position yields a value only when all 4 samples agree. An edge is declared when a clean 0 was seen at the previous position and a clean 1 at the current one. Disagreeing samples yield no value and break the chain.
- R7: A clean 1 at the first position of a group, or any 1 that does not follow a clean 0, is not an edge. The search goes on until a 0-to-1 transition is found.
- R8: When an edge is declared, the fine and coarse counts of the position that gave the clean 1 are stored for that group. They are read on `rd_fine`/`rd_coarse` by putting the group index on `rd_grp`.
- R9: `edge_found` rises when the current group's edge is declared. It drops when the next group begins and stays high after the last group.
- R10: After the edge of the last group, `wl_done` goes high and `wl_state` reads 6. `wl_done` and `wl_err` are never high together, and both hold until the next accepted start.
- R11: If position fine 63, coarse 7 is evaluated without an edge, `wl_err` goes high and `wl_state` reads 7. `cur_grp` stays at the failing group, and later groups are not searched: their records remain 0.
- R12: `tap_inc_req` stays high from the moment a step is requested until `tap_inc_ack` is seen. Exactly one step is taken per acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_req | input | 1 | One-cycle request to start a pass |
| tap_inc_ack | input | 1 | Delay line has taken the requested step |
| dq_fb | input | 1 | Feedback bit returned on the data lines |
| rd_grp | input | GRP_W | Group index for record readback |
| tap_inc_req | output | 1 | Delay step request |
| tap_coarse | output | 1 | Kind of step requested: 0 fine, 1 coarse |
| wl_started | output | 1 | A pass has been started since reset |
| wl_done | output | 1 | Every group passed |
| wl_err | output | 1 | A group showed no edge |
| wl_state | output | 3 | Controller state code |
| cur_grp | output | GRP_W | Group under calibration |
| win_valid | output | 1 | Feedback sampling window active |
| edge_found | output | 1 | Edge found for the current group |
| rd_fine | output | 6 | Stored fine count of group `rd_grp` |
| rd_coarse | output | 3 | Stored coarse count of group `rd_grp` |

## Verification
The bound checker watches several properties on every cycle:
- done and error are never high together, and each holds once set;
- the step request is held until it is acknowledged;
- the sampling window opens only out of the settle state and never overlaps a step request;
- the group index moves only upward by one;
- edge-found and error are never high together.

Other behaviours only show up in the bench scenarios:
- the stored fine/coarse values;
- the exact settle gap and window length;
- the counts of fine versus coarse steps;
- rejection of a leading 1 and of noisy positions;
- the records left untouched after a failing group;
- a start request being ignored in mid-pass.

// File: rtl/wl_pkg.sv
package wl_pkg;

    localparam int FINE_W   = 6;
    localparam int COARSE_W = 3;
    localparam logic [FINE_W-1:0] FINE_TOP = {FINE_W{1'b1}};

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } tap_pos_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_SAMPLE = 3'd2,
        ST_EVAL   = 3'd3,
        ST_STEP   = 3'd4,
        ST_NEXT   = 3'd5,
        ST_DONE   = 3'd6,
        ST_FAIL   = 3'd7
    } wl_state_e;

    function automatic logic is_resting(wl_state_e s);
        return (s == ST_IDLE) || (s == ST_DONE) || (s == ST_FAIL);
    endfunction

    function automatic tap_pos_t tap_advance(tap_pos_t p, logic coarse_step);
        tap_pos_t n;
        if (coarse_step) begin
            n.coarse = p.coarse + 1'b1;
            n.fine   = '0;
        end else begin
            n.coarse = p.coarse;
            n.fine   = p.fine + 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/wl_settle_timer.sv
module wl_settle_timer #(
    parameter int SETTLE_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/wl_fb_filter.sv
module wl_fb_filter #(
    parameter int NUM_SAMPLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic din,
    output logic last,
    output logic stable,
    output logic level
);
    localparam int CW = $clog2(NUM_SAMPLES + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(NUM_SAMPLES - 1);

    logic [CW-1:0] cnt;
    logic          seen0;
    logic          seen1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt   <= '0;
            seen0 <= 1'b0;
            seen1 <= 1'b0;
        end else if (en) begin
            cnt   <= cnt + 1'b1;
            seen0 <= seen0 | ~din;
            seen1 <= seen1 | din;
        end
    end

    assign last   = en && (cnt == LAST_IDX);
    assign stable = seen0 ^ seen1;
    assign level  = seen1;
endmodule

// File: rtl/wl_tap_bank.sv
module wl_tap_bank
    import wl_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int GRP_W      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [GRP_W-1:0] wr_grp,
    input  tap_pos_t         wr_tap,
    input  logic [GRP_W-1:0] rd_grp,
    output tap_pos_t         rd_tap
);
    tap_pos_t rec [NUM_GROUPS];

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_rec
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                rec[g] <= '0;
            end else if (wr_en && (wr_grp == GRP_W'(g))) begin
                rec[g] <= wr_tap;
            end
        end
    end

    always_comb begin
        rd_tap = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (rd_grp == GRP_W'(g)) rd_tap = rec[g];
        end
    end
endmodule

// File: rtl/wl_cal_ctrl.sv
module wl_cal_ctrl
    import wl_pkg::*;
#(
    parameter int NUM_GROUPS  = 4,
    parameter int SETTLE_CYC  = 8,
    parameter int NUM_SAMPLES = 4,
    parameter int COARSE_MAX  = 7,
    localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cal_req,
    input  logic                tap_inc_ack,
    input  logic                dq_fb,
    input  logic [GRP_W-1:0]    rd_grp,
    output logic                tap_inc_req,
    output logic                tap_coarse,
    output logic                wl_started,
    output logic                wl_done,
    output logic                wl_err,
    output logic [2:0]          wl_state,
    output logic [GRP_W-1:0]    cur_grp,
    output logic                win_valid,
    output logic                edge_found,
    output logic [FINE_W-1:0]   rd_fine,
    output logic [COARSE_W-1:0] rd_coarse
);
    localparam logic [GRP_W-1:0]    LAST_GRP = GRP_W'(NUM_GROUPS - 1);
    localparam logic [COARSE_W-1:0] CTOP     = COARSE_W'(COARSE_MAX);

    wl_state_e        state;
    tap_pos_t         tap;
    logic             step_coarse;
    logic             prev_zero;
    logic [GRP_W-1:0] grp;
    logic             started_q, done_q, err_q, found_q;

    logic     settle_exp;
    logic     samp_last, samp_stable, samp_level;
    logic     start_ok;
    logic     hit;
    tap_pos_t rd_tap;

    assign start_ok = is_resting(state) && cal_req;
    assign hit      = (state == ST_EVAL) && samp_stable && samp_level && prev_zero;

    wl_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_SETTLE),
        .expired (settle_exp)
    );

    wl_fb_filter #(.NUM_SAMPLES(NUM_SAMPLES)) u_filter (
        .clk    (clk),
        .rst    (rst),
        .clr    (state == ST_SETTLE),
        .en     (state == ST_SAMPLE),
        .din    (dq_fb),
        .last   (samp_last),
        .stable (samp_stable),
        .level  (samp_level)
    );

    wl_tap_bank #(.NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .clr    (start_ok),
        .wr_en  (hit),
        .wr_grp (grp),
        .wr_tap (tap),
        .rd_grp (rd_grp),
        .rd_tap (rd_tap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            tap         <= '0;
            step_coarse <= 1'b0;
            prev_zero   <= 1'b0;
            grp         <= '0;
            started_q   <= 1'b0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
            found_q     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE, ST_FAIL: begin
                    if (cal_req) begin
                        state     <= ST_SETTLE;
                        tap       <= '0;
                        prev_zero <= 1'b0;
                        grp       <= '0;
                        started_q <= 1'b1;
                        done_q    <= 1'b0;
                        err_q     <= 1'b0;
                        found_q   <= 1'b0;
                    end
                end
                ST_SETTLE: begin
                    if (settle_exp) state <= ST_SAMPLE;
                end
                ST_SAMPLE: begin
                    if (samp_last) state <= ST_EVAL;
                end
                ST_EVAL: begin
                    if (hit) begin
                        found_q <= 1'b1;
                        state   <= ST_NEXT;
                    end else begin
                        prev_zero <= samp_stable && !samp_level;
                        if (tap.fine == FINE_TOP) begin
                            if (tap.coarse == CTOP) begin
                                err_q <= 1'b1;
                                state <= ST_FAIL;
                            end else begin
                                step_coarse <= 1'b1;
                                state       <= ST_STEP;
                            end
                        end else begin
                            step_coarse <= 1'b0;
                            state       <= ST_STEP;
                        end
                    end
                end
                ST_STEP: begin
                    if (tap_inc_ack) begin
                        tap   <= tap_advance(tap, step_coarse);
                        state <= ST_SETTLE;
                    end
                end
                ST_NEXT: begin
                    if (grp == LAST_GRP) begin
                        done_q <= 1'b1;
                        state  <= ST_DONE;
                    end else begin
                        grp       <= grp + 1'b1;
                        tap       <= '0;
                        prev_zero <= 1'b0;
                        found_q   <= 1'b0;
                        state     <= ST_SETTLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign tap_inc_req = (state == ST_STEP);
    assign tap_coarse  = step_coarse;
    assign wl_started  = started_q;
    assign wl_done     = done_q;
    assign wl_err      = err_q;
    assign wl_state    = state;
    assign cur_grp     = grp;
    assign win_valid   = (state == ST_SAMPLE);
    assign edge_found  = found_q;
    assign rd_fine     = rd_tap.fine;
    assign rd_coarse   = rd_tap.coarse;
endmodule

// File: rtl/wl_cal_chk.sv
module wl_cal_chk #(
    parameter int GRP_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             cal_req,
    input logic             tap_inc_req,
    input logic             tap_inc_ack,
    input logic             wl_done,
    input logic             wl_err,
    input logic [2:0]       wl_state,
    input logic [GRP_W-1:0] cur_grp,
    input logic             win_valid,
    input logic             edge_found
);
    a_r10_done_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(wl_done && wl_err));

    a_r10_done_holds: assert property (@(posedge clk) disable iff (rst)
        (wl_done && !cal_req) |=> wl_done);

    a_r11_err_holds: assert property (@(posedge clk) disable iff (rst)
        (wl_err && !cal_req) |=> (wl_err && $stable(cur_grp)));

    a_r12_req_held: assert property (@(posedge clk) disable iff (rst)
        (tap_inc_req && !tap_inc_ack) |=> tap_inc_req);

    a_r5_no_step_in_window: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> !tap_inc_req);

    a_r5_window_after_settle: assert property (@(posedge clk) disable iff (rst)
        $rose(win_valid) |-> ($past(wl_state) == 3'd1));

    a_r3_grp_up_by_one: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_grp) |-> ((cur_grp == GRP_W'($past(cur_grp) + 1'b1)) || (cur_grp == '0)));

    a_r9_edge_not_err: assert property (@(posedge clk) disable iff (rst)
        edge_found |-> !wl_err);
endmodule

bind wl_cal_ctrl wl_cal_chk #(.GRP_W(GRP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cal_req     (cal_req),
    .tap_inc_req (tap_inc_req),
    .tap_inc_ack (tap_inc_ack),
    .wl_done     (wl_done),
    .wl_err      (wl_err),
    .wl_state    (wl_state),
    .cur_grp     (cur_grp),
    .win_valid   (win_valid),
    .edge_found  (edge_found)
);

// File: tb/wl_cal_ctrl_bench.sv
module wl_cal_ctrl_bench;
    localparam int NG = 4;
    localparam int GW = 2;
    localparam int NEVER = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cal_req = 1'b0;
    logic          tap_inc_ack = 1'b0;
    logic          dq_fb;
    logic [GW-1:0] rd_grp = '0;
    logic          tap_inc_req, tap_coarse, wl_started, wl_done, wl_err;
    logic [2:0]    wl_state;
    logic [GW-1:0] cur_grp;
    logic          win_valid, edge_found;
    logic [5:0]    rd_fine;
    logic [2:0]    rd_coarse;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // delay line and feedback model
    int pos = 0;
    int fine_steps = 0;
    int coarse_steps = 0;
    int edge_at [NG];
    int hi_until [NG];
    int noisy_at [NG];

    // monitors
    int  gap = 0;
    bit  armed = 0;
    int  gap_bad = 0;
    int  wlen = 0;
    int  wlen_bad = 0;
    int  edge_rises = 0;
    bit  prev_edge = 0;
    int  grp_bad = 0;
    logic [GW-1:0] prev_grp = '0;

    wl_cal_ctrl u_wl_cal_ctrl (
        .clk(clk), .rst(rst), .cal_req(cal_req), .tap_inc_ack(tap_inc_ack),
        .dq_fb(dq_fb), .rd_grp(rd_grp), .tap_inc_req(tap_inc_req),
        .tap_coarse(tap_coarse), .wl_started(wl_started), .wl_done(wl_done),
        .wl_err(wl_err), .wl_state(wl_state), .cur_grp(cur_grp),
        .win_valid(win_valid), .edge_found(edge_found),
        .rd_fine(rd_fine), .rd_coarse(rd_coarse)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wl_state == 3'd0 || wl_state == 3'd6 || wl_state == 3'd7 || wl_state == 3'd5) begin
            pos <= 0;
        end
        if (tap_inc_req && !tap_inc_ack) begin
            tap_inc_ack <= 1'b1;
            if (tap_coarse) begin
                pos <= (pos / 64 + 1) * 64;
                coarse_steps <= coarse_steps + 1;
            end else begin
                pos <= pos + 1;
                fine_steps <= fine_steps + 1;
            end
        end else begin
            tap_inc_ack <= 1'b0;
        end
    end

    always_comb begin
        if (pos == noisy_at[cur_grp])     dq_fb = cyc[0];
        else if (pos < hi_until[cur_grp]) dq_fb = 1'b1;
        else                              dq_fb = (pos >= edge_at[cur_grp]);
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (tap_inc_ack) begin
                armed = 1; gap = 0;
            end else if (armed && !win_valid) begin
                gap++;
            end else if (armed && win_valid) begin
                if (gap != 8) gap_bad++;
                armed = 0;
            end
            if (win_valid) wlen++;
            else if (wlen != 0) begin
                if (wlen != 4) wlen_bad++;
                wlen = 0;
            end
            if (edge_found && !prev_edge) edge_rises++;
            prev_edge = edge_found;
            if (cur_grp != prev_grp && cur_grp != GW'(prev_grp + 1'b1) && cur_grp != '0) grp_bad++;
            prev_grp = cur_grp;
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_group(input int g, input int e, input int hi, input int nz);
        edge_at[g] = e; hi_until[g] = hi; noisy_at[g] = nz;
    endtask

    task automatic launch();
        fine_steps = 0; coarse_steps = 0; gap_bad = 0; wlen_bad = 0;
        edge_rises = 0; grp_bad = 0;
        @(negedge clk); cal_req = 1'b1;
        @(negedge clk); cal_req = 1'b0;
    endtask

    task automatic wait_end();
        while (!(wl_done || wl_err) && cyc < 150000) @(negedge clk);
        if (cyc >= 150000) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
        @(negedge clk);
    endtask

    task automatic check_rec(input string req, input int g, input int fine, input int coarse);
        rd_grp = GW'(g);
        #1;
        check(req, rd_fine, fine, $sformatf("fine of group %0d", g));
        check(req, rd_coarse, coarse, $sformatf("coarse of group %0d", g));
    endtask

    task automatic check_monitors(input int exp_edges);
        check("R5", gap_bad, 0, "settle gap not 8 cycles");
        check("R5", wlen_bad, 0, "window not 4 cycles");
        check("R3", grp_bad, 0, "group index jumped");
        check("R9", edge_rises, exp_edges, "edge_found rises");
    endtask

    task automatic t_reset();
        check("R1", wl_state, 0, "state after reset");
        check("R1", wl_started + wl_done + wl_err + edge_found + win_valid + tap_inc_req, 0, "flags after reset");
        check("R1", cur_grp, 0, "group after reset");
        for (int g = 0; g < NG; g++) check_rec("R1", g, 0, 0);
    endtask

    task automatic t_all_pass();
        set_group(0, 17, 0, -1);
        set_group(1, 100, 0, -1);
        set_group(2, 511, 0, -1);
        set_group(3, 64, 0, -1);
        launch();
        check("R2", wl_started, 1, "started after request");
        wait_end();
        check("R10", wl_done, 1, "done");
        check("R10", wl_err, 0, "error on success");
        check("R10", wl_state, 6, "state code done");
        check("R3", cur_grp, 3, "final group");
        check("R4", fine_steps, 683, "fine steps");
        check("R4", coarse_steps, 9, "coarse steps");
        check_rec("R8", 0, 17, 0);
        check_rec("R8", 1, 36, 1);
        check_rec("R8", 2, 63, 7);
        check_rec("R8", 3, 0, 1);
        check("R9", edge_found, 1, "edge flag after last group");
        check_monitors(4);
    endtask

    task automatic t_fail();
        set_group(0, 10, 0, -1);
        set_group(1, NEVER, 0, -1);
        set_group(2, 5, 0, -1);
        set_group(3, 5, 0, -1);
        launch();
        check("R10", wl_done, 0, "done cleared by new start");
        wait_end();
        check("R11", wl_err, 1, "error");
        check("R11", wl_done, 0, "done on failure");
        check("R11", wl_state, 7, "state code fail");
        check("R11", cur_grp, 1, "failing group held");
        check("R11", coarse_steps, 7, "coarse steps up to limit");
        check("R4", fine_steps, 514, "fine steps");
        check_rec("R8", 0, 10, 0);
        check_rec("R11", 1, 0, 0);
        check_rec("R11", 2, 0, 0);
        check_rec("R11", 3, 0, 0);
        check("R9", edge_found, 0, "edge flag on failed group");
        check_monitors(1);
        repeat (20) @(negedge clk);
        check("R11", wl_err, 1, "error holds");
    endtask

    task automatic t_leading_one_noise();
        set_group(0, 20, 3, -1);
        set_group(1, 30, 0, 5);
        set_group(2, 1, 0, -1);
        set_group(3, 63, 0, -1);
        launch();
        check("R2", wl_err, 0, "error cleared by new start");
        repeat (300) @(negedge clk);
        cal_req = 1'b1;
        @(negedge clk);
        cal_req = 1'b0;
        wait_end();
        check("R10", wl_done, 1, "done");
        check_rec("R7", 0, 20, 0);
        check_rec("R6", 1, 30, 0);
        check_rec("R8", 2, 1, 0);
        check_rec("R4", 3, 63, 0);
        check("R2", fine_steps, 114, "fine steps with mid-run request");
        check("R4", coarse_steps, 0, "coarse steps");
        check_monitors(4);
    endtask

    initial begin
        for (int g = 0; g < NG; g++) set_group(g, NEVER, 0, -1);
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_all_pass();
        t_fail();
        t_leading_one_noise();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        forever begin
            @(negedge clk);
            if (cyc > 190000) begin
                fails++;
                $display("FAIL watchdog: bench hung");
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end
endmodule